// File: doc/BRIEF.md
# Locked Instruction Sequence Controller

This block opens a short protected window over the next few instructions a processor core retires. A start command carries a kind code and a length. While the window is open, ordinary interrupts, event-transfer interrupts and low-class traps are held off. Depending on the kind, the block also steers data accesses. It can select the extended special-register range, replace data-page translation with a supplied 10-bit page number, or replace it with a supplied 8-bit segment number. Some kinds apply a page or segment override together with the extended register range.

One down-counter drives every output. It is loaded from the length operand when a start command arrives and drops by one for each retire strobe. The window closes when the counter reaches zero. A severe (high-class) trap closes it at once, whatever the count. Decoding the command, arbitrating interrupts and forming addresses are left to the neighbouring logic.

Top module: `lockseq_ctrl`

## Requirements
- R1: A synchronous reset, with `rst_n` low at a rising edge, leaves every output low (masks, override flags and value buses) from the next cycle on. This also holds when a window is open.
- R2: Kind codes are: 0 lock only, 1 extended registers, 2 page, 3 segment, 4 page with extended registers, 5 segment with extended registers. A start command with code 6 or 7 is ignored: the outputs and the remaining count stay as they were.
- R3: The length operand is clamped to 1..4. A value of 0 acts as 1, and 5 to 7 act as 4. With clamped length L, `irq_mask_o` stays high until the L-th retire strobe after the start and is low from the next cycle on.
- R4: Only a cycle with `retire_i` high decrements the count. Cycles without a retire strobe leave the window open and the outputs unchanged.
- R5: Kinds 1, 4 and 5 raise `ext_reg_o` for the whole window. Kinds 0, 2 and 3 keep it low.
- R6: Kinds 2 and 4 raise `page_ovr_o` and drive `page_val_o` with the 10-bit page operand captured at the start. Kinds 3 and 5 raise `seg_ovr_o` and drive `seg_val_o` with the captured 8-bit segment operand.
- R7: Every override output (`ext_reg_o`, `page_ovr_o`, `seg_ovr_o`) is high only while `irq_mask_o` is high.
- R8: In any cycle where `severe_trap_i` is high, all outputs are low in that same cycle. The window is closed from then on. A start command in a trap cycle is dropped.
- R9: A valid start command inside an open window reloads the count, the kind and the operand values.
- R10: `page_val_o` is zero whenever `page_ovr_o` is low, and `seg_val_o` is zero whenever `seg_ovr_o` is low.
- R11: A retire strobe in the same cycle as a valid start command belongs to the start command and does not shorten the new window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Start command strobe |
| start_kind_i | input | 3 | Kind code of the start command |
| start_len_i | input | 3 | Requested window length in instructions |
| start_page_i | input | 10 | Page number operand |
| start_seg_i | input | 8 | Segment number operand |
| retire_i | input | 1 | One instruction retired this cycle |
| severe_trap_i | input | 1 | High-class trap condition |
| irq_mask_o | output | 1 | Hold off interrupts and low-class traps |
| ext_reg_o | output | 1 | Select the extended special-register range |
| page_ovr_o | output | 1 | Page override active |
| page_val_o | output | 10 | Override page number |
| seg_ovr_o | output | 1 | Segment override active |
| seg_val_o | output | 8 | Override segment number |

## Verification
The bench sweeps all eight kind codes against all eight length operands. For each pair it checks the window cycle by cycle, with idle cycles placed between retires. A clamp off by one shows up as a window one retire too long or too short, and a counter that also counted idle cycles would close early. Targeted cases cover a trap in mid-window and a trap together with a start, a restart inside a window, a start that shares its cycle with a retire, a reserved kind issued mid-window, and a reset mid-window. A design that registered the trap would leave the mask high for one extra cycle. Keeping stale operands would show the old page after a restart, and letting the start cycle's retire count would end the window one instruction early.

// File: rtl/lockseq_pkg.sv
// Shared kind codes and override flag bundle for the locked sequence controller.
// Assumes a 3-bit kind field; codes above KIND_SEG_XREG are reserved.
package lockseq_pkg;

    typedef enum logic [2:0] {
        KIND_LOCK      = 3'd0,
        KIND_XREG      = 3'd1,
        KIND_PAGE      = 3'd2,
        KIND_SEG       = 3'd3,
        KIND_PAGE_XREG = 3'd4,
        KIND_SEG_XREG  = 3'd5
    } seq_kind_e;

    typedef struct packed {
        logic xreg;
        logic page;
        logic seg;
    } ovr_flags_t;

endpackage

// File: rtl/lockseq_len_clamp.sv
// Clamps the requested window length into 1..MAX_LEN.
// Purely combinational; assumes MAX_LEN fits in CNT_W bits.
module lockseq_len_clamp #(
    parameter int LEN_W   = 3,
    parameter int MAX_LEN = 4,
    parameter int CNT_W   = $clog2(MAX_LEN + 1)
) (
    input  logic [LEN_W-1:0] len_i,
    output logic [CNT_W-1:0] len_o
);

    localparam logic [LEN_W-1:0] MAX_IN  = LEN_W'(MAX_LEN);
    localparam logic [CNT_W-1:0] MAX_CNT = CNT_W'(MAX_LEN);

    // Map zero to one and oversize requests to the ceiling.
    always_comb begin
        if (len_i == '0)
            len_o = CNT_W'(1);
        else if (len_i > MAX_IN)
            len_o = MAX_CNT;
        else
            len_o = CNT_W'(len_i);
    end

endmodule

// File: rtl/lockseq_kind_decode.sv
// Turns a kind code into override flags and a validity bit.
// Purely combinational; reserved codes give valid_o low and no flags.
module lockseq_kind_decode
    import lockseq_pkg::*;
(
    input  logic [2:0]  kind_i,
    output ovr_flags_t  flags_o,
    output logic        valid_o
);

    // One row per defined kind; everything else is reserved.
    always_comb begin
        flags_o = '0;
        valid_o = 1'b1;
        case (kind_i)
            KIND_LOCK:      flags_o = '0;
            KIND_XREG:      flags_o.xreg = 1'b1;
            KIND_PAGE:      flags_o.page = 1'b1;
            KIND_SEG:       flags_o.seg  = 1'b1;
            KIND_PAGE_XREG: begin flags_o.page = 1'b1; flags_o.xreg = 1'b1; end
            KIND_SEG_XREG:  begin flags_o.seg  = 1'b1; flags_o.xreg = 1'b1; end
            default:        valid_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/lockseq_count.sv
// Remaining-instruction counter of the protected window.
// Priority: reset, flush, load, step. Stepping at zero is ignored.
module lockseq_count #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush_i,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             step_i,
    output logic [CNT_W-1:0] cnt_o
);

    logic [CNT_W-1:0] cnt_q;

    // Track instructions still owed to the window.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (flush_i)
            cnt_q <= '0;
        else if (load_i)
            cnt_q <= load_val_i;
        else if (step_i && cnt_q != '0)
            cnt_q <= cnt_q - CNT_W'(1);
    end

    assign cnt_o = cnt_q;

endmodule

// File: rtl/lockseq_ctrl.sv
// Locked instruction sequence controller: opens a window of 1..MAX_LEN retired
// instructions with interrupts held off and optional address overrides.
// Assumes retire_i pulses once per retired instruction, and that the start
// command's own retire, if it shares the cycle, is not part of the window.
module lockseq_ctrl
    import lockseq_pkg::*;
#(
    parameter int LEN_W   = 3,
    parameter int MAX_LEN = 4,
    parameter int PAGE_W  = 10,
    parameter int SEG_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [2:0]        start_kind_i,
    input  logic [LEN_W-1:0]  start_len_i,
    input  logic [PAGE_W-1:0] start_page_i,
    input  logic [SEG_W-1:0]  start_seg_i,
    input  logic              retire_i,
    input  logic              severe_trap_i,
    output logic              irq_mask_o,
    output logic              ext_reg_o,
    output logic              page_ovr_o,
    output logic [PAGE_W-1:0] page_val_o,
    output logic              seg_ovr_o,
    output logic [SEG_W-1:0]  seg_val_o
);

    localparam int CNT_W = $clog2(MAX_LEN + 1);

    ovr_flags_t        dec_flags;
    logic              dec_valid;
    logic [CNT_W-1:0]  len_clamped;
    logic [CNT_W-1:0]  cnt;
    logic              start_ok;
    logic              active;
    ovr_flags_t        flags_q;
    logic [PAGE_W-1:0] page_q;
    logic [SEG_W-1:0]  seg_q;

    lockseq_kind_decode u_dec (
        .kind_i  (start_kind_i),
        .flags_o (dec_flags),
        .valid_o (dec_valid)
    );

    lockseq_len_clamp #(
        .LEN_W   (LEN_W),
        .MAX_LEN (MAX_LEN),
        .CNT_W   (CNT_W)
    ) u_clamp (
        .len_i (start_len_i),
        .len_o (len_clamped)
    );

    // A start counts only with a defined kind and no trap in the same cycle.
    assign start_ok = start_i && dec_valid && !severe_trap_i;

    lockseq_count #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush_i    (severe_trap_i),
        .load_i     (start_ok),
        .load_val_i (len_clamped),
        .step_i     (retire_i),
        .cnt_o      (cnt)
    );

    // Capture kind flags and operand values for the window being opened.
    always_ff @(posedge clk) begin
        if (!rst_n || severe_trap_i) begin
            flags_q <= '0;
            page_q  <= '0;
            seg_q   <= '0;
        end else if (start_ok) begin
            flags_q <= dec_flags;
            page_q  <= start_page_i;
            seg_q   <= start_seg_i;
        end
    end

    // Window is live while instructions remain and no severe trap is present.
    assign active = (cnt != '0) && !severe_trap_i;

    // Gate every output with the live window; value buses read zero when idle.
    always_comb begin
        irq_mask_o = active;
        ext_reg_o  = active && flags_q.xreg;
        page_ovr_o = active && flags_q.page;
        seg_ovr_o  = active && flags_q.seg;
        page_val_o = page_ovr_o ? page_q : '0;
        seg_val_o  = seg_ovr_o  ? seg_q  : '0;
    end

endmodule

// File: rtl/lockseq_ctrl_chk.sv
// Temporal checks on the locked sequence controller ports, bound to every
// instance of lockseq_ctrl. Assumes the default operand widths.
module lockseq_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start_i,
    input logic [2:0] start_kind_i,
    input logic       retire_i,
    input logic       severe_trap_i,
    input logic       irq_mask_o,
    input logic       ext_reg_o,
    input logic       page_ovr_o,
    input logic [9:0] page_val_o,
    input logic       seg_ovr_o,
    input logic [7:0] seg_val_o
);

    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (!irq_mask_o && !ext_reg_o && !page_ovr_o && !seg_ovr_o));

    p_start_opens_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && start_kind_i <= 3'd5 && !severe_trap_i) |=> (irq_mask_o || severe_trap_i));

    p_idle_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_mask_o && !retire_i && !start_i) |=> (irq_mask_o || severe_trap_i));

    p_ovr_in_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_reg_o || page_ovr_o || seg_ovr_o) |-> irq_mask_o);

    p_trap_now_r8: assert property (@(posedge clk) disable iff (!rst_n)
        severe_trap_i |-> !irq_mask_o);

    p_trap_closes_r8: assert property (@(posedge clk) disable iff (!rst_n)
        severe_trap_i |=> !irq_mask_o);

    p_page_steady_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (page_ovr_o && !start_i) |=> (!page_ovr_o || $stable(page_val_o)));

    p_val_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!page_ovr_o |-> page_val_o == '0) and (!seg_ovr_o |-> seg_val_o == '0));

endmodule

bind lockseq_ctrl lockseq_ctrl_chk u_lockseq_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_i       (start_i),
    .start_kind_i  (start_kind_i),
    .retire_i      (retire_i),
    .severe_trap_i (severe_trap_i),
    .irq_mask_o    (irq_mask_o),
    .ext_reg_o     (ext_reg_o),
    .page_ovr_o    (page_ovr_o),
    .page_val_o    (page_val_o),
    .seg_ovr_o     (seg_ovr_o),
    .seg_val_o     (seg_val_o)
);

// File: tb/lockseq_ctrl_bench.sv
`timescale 1ns/1ps
// Self-checking bench: sweeps every kind and length, then targets traps,
// restarts, shared start/retire cycles, reserved kinds and reset.
module lockseq_ctrl_bench;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       start_i;
    logic [2:0] start_kind_i;
    logic [2:0] start_len_i;
    logic [9:0] start_page_i;
    logic [7:0] start_seg_i;
    logic       retire_i;
    logic       severe_trap_i;
    logic       irq_mask_o;
    logic       ext_reg_o;
    logic       page_ovr_o;
    logic [9:0] page_val_o;
    logic       seg_ovr_o;
    logic [7:0] seg_val_o;

    int  checks = 0;
    int  errors = 0;
    bit  done   = 1'b0;

    always #2.5 clk = ~clk;

    lockseq_ctrl u_lockseq_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_i       (start_i),
        .start_kind_i  (start_kind_i),
        .start_len_i   (start_len_i),
        .start_page_i  (start_page_i),
        .start_seg_i   (start_seg_i),
        .retire_i      (retire_i),
        .severe_trap_i (severe_trap_i),
        .irq_mask_o    (irq_mask_o),
        .ext_reg_o     (ext_reg_o),
        .page_ovr_o    (page_ovr_o),
        .page_val_o    (page_val_o),
        .seg_ovr_o     (seg_ovr_o),
        .seg_val_o     (seg_val_o)
    );

    function automatic logic [9:0] pg_of(int k, int l);
        return 10'((k * 97 + l * 13 + 5) & 32'h3FF);
    endfunction

    function automatic logic [7:0] sg_of(int k, int l);
        return 8'((k * 29 + l * 7 + 1) & 32'hFF);
    endfunction

    function automatic int clamp_len(int l);
        return (l == 0) ? 1 : ((l > 4) ? 4 : l);
    endfunction

    // Compare every output against expectation for a window of kind k.
    task automatic expect_win(string req, bit open, int k, logic [9:0] pg, logic [7:0] sg);
        bit         ex, ep, es;
        logic [9:0] epv;
        logic [7:0] esv;
        ex  = open && (k == 1 || k == 4 || k == 5);
        ep  = open && (k == 2 || k == 4);
        es  = open && (k == 3 || k == 5);
        epv = ep ? pg : 10'h0;
        esv = es ? sg : 8'h0;
        checks++;
        if ({irq_mask_o, ext_reg_o, page_ovr_o, page_val_o, seg_ovr_o, seg_val_o}
            !== {open, ex, ep, epv, es, esv}) begin
            errors++;
            $display("FAIL %s: got m=%b x=%b p=%b pv=%h s=%b sv=%h, exp m=%b x=%b p=%b pv=%h s=%b sv=%h",
                     req, irq_mask_o, ext_reg_o, page_ovr_o, page_val_o, seg_ovr_o, seg_val_o,
                     open, ex, ep, epv, es, esv);
        end
    endtask

    task automatic drive_start(int k, int l, logic [9:0] pg, logic [7:0] sg);
        start_i      = 1'b1;
        start_kind_i = 3'(k);
        start_len_i  = 3'(l);
        start_page_i = pg;
        start_seg_i  = sg;
    endtask

    // Sweep: one window per kind/length pair, idle cycle before second retire.
    task automatic sweep_case(int k, int l);
        int         len;
        bit         valid;
        logic [9:0] pg;
        logic [7:0] sg;
        len   = clamp_len(l);
        valid = (k <= 5);
        pg    = pg_of(k, l);
        sg    = sg_of(k, l);
        @(negedge clk);
        drive_start(k, l, pg, sg);
        @(negedge clk);
        start_i = 1'b0;
        expect_win(valid ? "R2 open" : "R2 reserved", valid, k, pg, sg);
        if (valid) begin
            for (int s = 1; s <= len; s++) begin
                if (s == 2) begin
                    @(negedge clk);
                    expect_win("R4 idle hold", 1'b1, k, pg, sg);
                end
                retire_i = 1'b1;
                @(negedge clk);
                retire_i = 1'b0;
                expect_win((s < len) ? "R3 R5 R6 mid" : "R3 R10 end", s < len, k, pg, sg);
            end
        end
    endtask

    initial begin
        rst_n = 1'b0; start_i = 1'b0; start_kind_i = '0; start_len_i = '0;
        start_page_i = '0; start_seg_i = '0; retire_i = 1'b0; severe_trap_i = 1'b0;
        repeat (3) @(negedge clk);
        expect_win("R1 reset", 1'b0, 0, '0, '0);
        rst_n = 1'b1;

        // Exhaustive kind x length sweep (R2 R3 R4 R5 R6 R7 R10).
        for (int k = 0; k < 8; k++)
            for (int l = 0; l < 8; l++)
                sweep_case(k, l);

        // R8: trap in mid-window drops outputs in the same cycle.
        @(negedge clk);
        drive_start(4, 4, 10'h155, 8'h00);
        @(negedge clk);
        start_i = 1'b0; retire_i = 1'b1;
        @(negedge clk);
        retire_i = 1'b0;
        expect_win("R8 before trap", 1'b1, 4, 10'h155, 8'h00);
        severe_trap_i = 1'b1;
        #1;
        expect_win("R8 trap same cycle", 1'b0, 4, 10'h155, 8'h00);
        @(negedge clk);
        severe_trap_i = 1'b0;
        expect_win("R8 after trap", 1'b0, 4, 10'h155, 8'h00);
        retire_i = 1'b1;
        @(negedge clk);
        retire_i = 1'b0;
        expect_win("R8 stays closed", 1'b0, 4, 10'h155, 8'h00);

        // R8: start in a trap cycle is dropped.
        drive_start(3, 4, 10'h0, 8'hC3);
        severe_trap_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0; severe_trap_i = 1'b0;
        expect_win("R8 start dropped", 1'b0, 3, 10'h0, 8'hC3);

        // R9: restart reloads count, kind and operands.
        drive_start(2, 4, 10'h2A7, 8'h11);
        @(negedge clk);
        start_i = 1'b0; retire_i = 1'b1;
        @(negedge clk);
        retire_i = 1'b0;
        drive_start(5, 2, 10'h3FF, 8'h9E);
        @(negedge clk);
        start_i = 1'b0;
        expect_win("R9 reloaded kind", 1'b1, 5, 10'h0, 8'h9E);
        retire_i = 1'b1;
        @(negedge clk);
        expect_win("R9 one left", 1'b1, 5, 10'h0, 8'h9E);
        @(negedge clk);
        retire_i = 1'b0;
        expect_win("R9 new length", 1'b0, 5, 10'h0, 8'h9E);

        // R11: retire sharing the start cycle does not count.
        drive_start(1, 2, 10'h0, 8'h0);
        retire_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0; retire_i = 1'b0;
        expect_win("R11 full load", 1'b1, 1, 10'h0, 8'h0);
        retire_i = 1'b1;
        @(negedge clk);
        expect_win("R11 after first", 1'b1, 1, 10'h0, 8'h0);
        @(negedge clk);
        retire_i = 1'b0;
        expect_win("R11 after second", 1'b0, 1, 10'h0, 8'h0);

        // R2: reserved kind inside an open window changes nothing.
        drive_start(3, 3, 10'h0, 8'h5A);
        @(negedge clk);
        drive_start(7, 1, 10'h3C3, 8'hFF);
        @(negedge clk);
        start_i = 1'b0;
        expect_win("R2 reserved mid-window", 1'b1, 3, 10'h0, 8'h5A);
        retire_i = 1'b1;
        @(negedge clk);
        retire_i = 1'b0;
        expect_win("R2 count kept", 1'b1, 3, 10'h0, 8'h5A);

        // R1: reset in the middle of a window closes it.
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        expect_win("R1 reset mid-window", 1'b0, 3, 10'h0, 8'h5A);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got hang, exp completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule